// File: doc/BRIEF.md
# Paged Address Translator with Associative Cache

This block turns a logical address from a processor into a physical address. The logical address has two fields. The upper bits are a virtual page number and the lower bits are an offset inside the page. The page size is a compile-time parameter. The translation for each page comes from a single-level page table in memory. A base input gives the byte address of that table and a length input gives its entry count. A small fully associative cache of recent translations sits in front of the table. The requested page number is compared with every cache entry at once, and a hit completes without touching memory.

On a miss the block issues one read of the page-table entry through a simple request/response memory port. It then completes the translation and, when the entry is valid, installs it in the cache. Victims are chosen in round-robin order. A single-cycle flush input empties the cache. Each completed request yields a one-cycle response with either a physical address or a fault flag. A page number beyond the table length, or an entry whose valid bit is clear, gives a fault.

Top module: `page_xlator`

## Requirements
- R1: The offset is the low log2(PAGE_BYTES) bits of the logical address, with PAGE_BYTES a power of two from 512 to 8192 (default 4096). The physical address is the frame number placed above that offset, and the offset itself is unchanged.
- R2: A request whose page is cached produces respValid in the cycle after it is accepted, with no memory read.
- R3: A request that misses issues exactly one one-cycle memory read at address ptBase + 4 * page number. respValid follows in the cycle after memRespValid.
- R4: A page-table entry is 32 bits. Bit 31 is the valid bit and the low FRAME_W bits are the frame number. A fetched entry with bit 31 clear gives respFault = 1 with respPaddr = 0.
- R5: A page number greater than or equal to ptLen gives a fault in the cycle after acceptance. No memory read is issued, and this check takes priority over a cache hit.
- R6: An entry fetched with its valid bit clear is not installed, so the same page fetches again on its next request.
- R7: A valid fetched entry is installed, so the next request for that page hits.
- R8: The cache has TLB_N = 8 entries, filled in round-robin order from entry 0 after reset or flush. The ninth distinct fill evicts the first page filled.
- R9: A one-cycle flush pulse invalidates every entry, so the next request for any page misses.
- R10: When flush arrives on the same clock edge as a fill, flush wins and nothing is installed. The translation in progress is still delivered correctly.
- R11: After reset, reqReady = 1, respValid = 0 and memReqValid = 0. reqReady stays low from the acceptance of a missing request until it completes, and requests offered in that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | One-cycle pulse that empties the translation cache |
| ptBase | input | MEM_AW | Byte address of page table entry 0 |
| ptLen | input | VPN_W+1 | Number of entries in the page table |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Block is able to accept a request |
| reqVaddr | input | VA_W | Logical address to translate |
| respValid | output | 1 | One-cycle completion pulse |
| respFault | output | 1 | Completion is a fault |
| respPaddr | output | PA_W | Physical address (zero on fault) |
| memReqValid | output | 1 | One-cycle page-table read request |
| memReqAddr | output | MEM_AW | Byte address of the entry being read |
| memRespValid | input | 1 | Read data is present |
| memRespData | input | 32 | Page-table entry read from memory |

## Verification
Two events can fall on the same edge: a fill of a fetched entry and a flush of the whole cache. The bench's memory model raises flush in the same cycle as it returns the entry. The completion must still carry the right physical address. A second request for that page must then produce a fresh memory read, which shows the fill was dropped. A request offered while a miss is in flight is also tested. It must produce neither a read nor a response of its own.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} xlatState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch page number and offset of a missing request
    logic install;   // write fetched entry into the cache
    logic finish;    // complete the current request next cycle
    logic fault;     // completion is a fault
    logic useMem;    // frame comes from memory data rather than the cache
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        tlbHit,
  input  logic        lenFault,
  input  logic        memRespValid,
  input  logic        pteValid,
  output xlatStrobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid
);
  xlatState_t stateQ, stateD;

  assign reqReady    = (stateQ == ST_IDLE);
  assign memReqValid = (stateQ == ST_ISSUE);

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (reqValid) begin
        if (lenFault) begin
          strobe.finish = 1'b1;
          strobe.fault  = 1'b1;
        end else if (tlbHit) begin
          strobe.finish = 1'b1;
        end else begin
          strobe.capture = 1'b1;
          stateD = ST_ISSUE;
        end
      end
      ST_ISSUE: stateD = ST_WAIT;
      ST_WAIT: if (memRespValid) begin
        strobe.finish  = 1'b1;
        strobe.useMem  = 1'b1;
        strobe.fault   = !pteValid;
        strobe.install = pteValid;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R5: an out-of-range page never reaches memory
  p_len_no_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && lenFault) |=> !memReqValid);

  // R2: a hit completes with no memory read
  p_hit_no_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !lenFault && tlbHit) |=> !memReqValid);

  // R11: a missing request holds the block busy
  p_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !lenFault && !tlbHit) |=> !reqReady);
endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int MEM_AW     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int TLB_N      = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int FRAME_W   = PA_W - OFF_W,
  localparam int IDX_W     = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlatStrobe_t       strobe,
  input  logic              flush,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [MEM_AW-1:0] ptBase,
  input  logic [VPN_W:0]    ptLen,
  input  logic [31:0]       memRespData,
  output logic              tlbHit,
  output logic              lenFault,
  output logic              pteValid,
  output logic [MEM_AW-1:0] memReqAddr,
  output logic              respValid,
  output logic              respFault,
  output logic [PA_W-1:0]   respPaddr
);
  localparam int PTE_SH = 2;

  if (PAGE_BYTES < 512 || PAGE_BYTES > 8192 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0)
  begin : g_badPage
    initial $fatal(1, "PAGE_BYTES must be a power of two from 512 to 8192");
  end

  logic [VPN_W-1:0]   tagQ   [TLB_N];
  logic [FRAME_W-1:0] frameQ [TLB_N];
  logic [TLB_N-1:0]   validQ;
  logic [IDX_W-1:0]   ptrQ;
  logic [TLB_N-1:0]   hitVec;
  logic [FRAME_W-1:0] hitFrame;
  logic [VPN_W-1:0]   vpnQ;
  logic [OFF_W-1:0]   offQ;

  wire [VPN_W-1:0]   reqVpn   = reqVaddr[VA_W-1:OFF_W];
  wire [OFF_W-1:0]   reqOff   = reqVaddr[OFF_W-1:0];
  wire [FRAME_W-1:0] memFrame = memRespData[FRAME_W-1:0];

  for (genvar i = 0; i < TLB_N; i++) begin : g_cmp
    assign hitVec[i] = validQ[i] && (tagQ[i] == reqVpn);
  end

  always_comb begin
    hitFrame = '0;
    for (int i = 0; i < TLB_N; i++)
      if (hitVec[i]) hitFrame = hitFrame | frameQ[i];
  end

  assign tlbHit     = |hitVec;
  assign lenFault   = ({1'b0, reqVpn} >= ptLen);
  assign pteValid   = memRespData[31];
  assign memReqAddr = ptBase + MEM_AW'({vpnQ, {PTE_SH{1'b0}}});

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      vpnQ <= reqVpn;
      offQ <= reqOff;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      validQ <= '0;
      ptrQ   <= '0;
    end else if (strobe.install) begin
      validQ[ptrQ] <= 1'b1;
      ptrQ <= (ptrQ == IDX_W'(TLB_N - 1)) ? '0 : ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && strobe.install) begin
      tagQ[ptrQ]   <= vpnQ;
      frameQ[ptrQ] <= memFrame;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respFault <= 1'b0;
      respPaddr <= '0;
    end else begin
      respValid <= strobe.finish;
      respFault <= strobe.finish && strobe.fault;
      if (strobe.fault)       respPaddr <= '0;
      else if (strobe.useMem) respPaddr <= {memFrame, offQ};
      else                    respPaddr <= {hitFrame, reqOff};
    end
  end

  // R9: flush leaves no live entry
  p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (validQ == '0));

  // R8: a page is never held in two entries
  p_single_match_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R7: an install without flush leaves the chosen entry live
  p_install_live_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.install && !flush) |=> validQ[$past(ptrQ)]);

  // R10: flush on a fill edge leaves the cache empty
  p_flush_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.install && flush) |=> ($countones(validQ) == 0));
endmodule

// File: rtl/page_xlator.sv
module page_xlator
  import xlat_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int MEM_AW     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int TLB_N      = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int VPN_W     = VA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic [MEM_AW-1:0] ptBase,
  input  logic [VPN_W:0]    ptLen,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  output logic              respValid,
  output logic              respFault,
  output logic [PA_W-1:0]   respPaddr,
  output logic              memReqValid,
  output logic [MEM_AW-1:0] memReqAddr,
  input  logic              memRespValid,
  input  logic [31:0]       memRespData
);
  xlatStrobe_t strobe;
  logic tlbHit, lenFault, pteValid;

  xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .tlbHit(tlbHit),
    .lenFault(lenFault), .memRespValid(memRespValid), .pteValid(pteValid),
    .strobe(strobe), .reqReady(reqReady), .memReqValid(memReqValid)
  );

  xlat_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .MEM_AW(MEM_AW),
    .PAGE_BYTES(PAGE_BYTES), .TLB_N(TLB_N)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flush(flush),
    .reqVaddr(reqVaddr), .ptBase(ptBase), .ptLen(ptLen),
    .memRespData(memRespData), .tlbHit(tlbHit), .lenFault(lenFault),
    .pteValid(pteValid), .memReqAddr(memReqAddr), .respValid(respValid),
    .respFault(respFault), .respPaddr(respPaddr)
  );
endmodule

// File: tb/page_xlator_tb.sv
module page_xlator_tb;
  localparam int OFF_W = 12;
  localparam int VPN_W = 20;
  localparam int FRAME_W = 20;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 0, rstN = 0, flush = 0, reqValid = 0, memRespValid = 0;
  logic [31:0] ptBase = BASE, reqVaddr = '0, memRespData = '0;
  logic [VPN_W:0] ptLen = 21'd40;
  logic reqReady, respValid, respFault, memReqValid;
  logic [31:0] respPaddr, memReqAddr;

  int nTests = 0, nFail = 0, readCount = 0, memLat = 2;
  logic [31:0] lastAddr;
  bit flushWithResp = 0;
  logic [31:0] pteMem [0:63];

  always #4 clk = ~clk;

  page_xlator u_dut (
    .clk(clk), .rstN(rstN), .flush(flush), .ptBase(ptBase), .ptLen(ptLen),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .respValid(respValid), .respFault(respFault), .respPaddr(respPaddr),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData)
  );

  function automatic logic [FRAME_W-1:0] frameOf(int v);
    return FRAME_W'(v * 3 + 256);
  endfunction

  // memory model: sees a read at a negedge, answers memLat cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        readCount++;
        lastAddr = memReqAddr;
        repeat (memLat) @(negedge clk);
        memRespData  = pteMem[(lastAddr - BASE) >> 2];
        memRespValid = 1;
        if (flushWithResp) flush = 1;
        @(negedge clk);
        memRespValid = 0;
        flush = 0;
      end
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic translate(input logic [31:0] va, output logic [31:0] pa,
                           output logic flt, output int cyc, output int rds);
    int r0;
    while (!reqReady) @(negedge clk);
    r0 = readCount;
    reqVaddr = va; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    cyc = 1;
    while (!respValid && cyc < 50) begin @(negedge clk); cyc++; end
    pa = respPaddr; flt = respFault;
    rds = readCount - r0;
    @(negedge clk);
  endtask

  task automatic pulseFlush();
    @(negedge clk); flush = 1; @(negedge clk); flush = 0;
  endtask

  function automatic logic [31:0] va(int v, int off);
    return {VPN_W'(v), OFF_W'(off)};
  endfunction

  function automatic logic [31:0] pa(int v, int off);
    return {frameOf(v), OFF_W'(off)};
  endfunction

  task automatic t_reset();
    check(reqReady == 1, "R11", "reqReady after reset", reqReady, 1);
    check(respValid == 0, "R11", "respValid after reset", respValid, 0);
    check(memReqValid == 0, "R11", "memReqValid after reset", memReqValid, 0);
  endtask

  task automatic t_miss_then_hit();
    logic [31:0] p; logic f; int c, r;
    translate(va(5, 'h123), p, f, c, r);
    check(r == 1, "R3", "miss reads", r, 1);
    check(lastAddr == BASE + 20, "R3", "entry address", lastAddr, BASE + 20);
    check(c == 4, "R3", "miss latency", c, 4);
    check(p == pa(5, 'h123) && !f, "R1", "miss paddr", p, pa(5, 'h123));
    translate(va(5, 'hFFF), p, f, c, r);
    check(r == 0, "R7", "hit reads", r, 0);
    check(c == 1, "R2", "hit latency", c, 1);
    check(p == pa(5, 'hFFF) && !f, "R1", "hit paddr offset", p, pa(5, 'hFFF));
  endtask

  task automatic t_invalid();
    logic [31:0] p; logic f; int c, r;
    translate(va(7, 'h10), p, f, c, r);
    check(f == 1, "R4", "invalid fault", f, 1);
    check(p == 0, "R4", "fault paddr", p, 0);
    translate(va(7, 'h10), p, f, c, r);
    check(r == 1 && f == 1, "R6", "invalid refetch reads", r, 1);
  endtask

  task automatic t_len();
    logic [31:0] p; logic f; int c, r;
    translate(va(40, 0), p, f, c, r);
    check(f == 1 && r == 0, "R5", "length fault no read", r, 0);
    check(c == 1, "R5", "length fault latency", c, 1);
    translate(va(39, 'h44), p, f, c, r);
    check(!f && p == pa(39, 'h44), "R5", "last legal page", p, pa(39, 'h44));
    ptLen = 21'd39;
    translate(va(39, 'h44), p, f, c, r);
    check(f == 1 && r == 0, "R5", "length beats cached hit", f, 1);
    ptLen = 21'd40;
  endtask

  task automatic t_flush();
    logic [31:0] p; logic f; int c, r;
    pulseFlush();
    translate(va(5, 1), p, f, c, r);
    check(r == 1, "R9", "read after flush", r, 1);
  endtask

  task automatic t_round_robin();
    logic [31:0] p; logic f; int c, r;
    pulseFlush();
    for (int v = 10; v <= 18; v++) translate(va(v, 0), p, f, c, r);
    translate(va(10, 0), p, f, c, r);
    check(r == 1, "R8", "first page evicted", r, 1);
    translate(va(12, 0), p, f, c, r);
    check(r == 0, "R8", "later page still cached", r, 0);
    translate(va(11, 0), p, f, c, r);
    check(r == 1, "R8", "second victim evicted", r, 1);
    translate(va(18, 0), p, f, c, r);
    check(r == 0, "R8", "ninth fill cached", r, 0);
  endtask

  task automatic t_flush_on_fill();
    logic [31:0] p; logic f; int c, r;
    pulseFlush();
    flushWithResp = 1;
    translate(va(21, 'hABC), p, f, c, r);
    flushWithResp = 0;
    check(p == pa(21, 'hABC) && !f, "R10", "paddr with flush", p, pa(21, 'hABC));
    translate(va(21, 'hABC), p, f, c, r);
    check(r == 1, "R10", "fill dropped", r, 1);
  endtask

  task automatic t_busy();
    int r0, pulses;
    pulses = 0;
    r0 = readCount;
    reqVaddr = va(22, 0); reqValid = 1;
    @(negedge clk);
    check(reqReady == 0, "R11", "busy after miss", reqReady, 0);
    reqVaddr = va(23, 0);
    for (int i = 0; i < 3; i++) begin
      if (respValid) pulses++;
      @(negedge clk);
    end
    reqValid = 0;
    for (int i = 0; i < 6; i++) begin
      if (respValid) pulses++;
      @(negedge clk);
    end
    check(pulses == 1, "R11", "responses while busy", pulses, 1);
    check(readCount - r0 == 1, "R11", "reads while busy", readCount - r0, 1);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    for (int v = 0; v < 64; v++) pteMem[v] = {1'b1, 11'b0, frameOf(v)};
    pteMem[7] = {1'b0, 11'b0, frameOf(7)};
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_miss_then_hit();
    t_invalid();
    t_len();
    t_flush();
    t_round_robin();
    t_flush_on_fill();
    t_busy();
    finishRun();
  end

  initial begin
    #(8 * 100000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule